// File: doc/BRIEF.md
# ADC Serial Frame Interface Controller

This block is the digital serial-port side of a multichannel successive-approximation converter. It runs on a system clock and oversamples three asynchronous pins: an active-low chip select, a serial clock and a serial data input. Each accepted frame does two things at once. It shifts a 16-bit command word in from the data input and writes the addressed configuration register at a fixed edge count. It also shifts a 16-bit result word out on the data output, with an output-enable that stands in for the pad's three-state control.

The analog conversion itself is not modelled. The channel number, sign and 12-bit result of the conversion to be reported arrive on a parallel port and are captured when a frame opens. The block produces a track/hold signal and a one-cycle conversion-start strobe for the analog side.

Between frames the data line is either released completely or held weakly at the first bit of the next frame's word. A control-register bit selects between the two. The weak drive is shown as a flag next to the data value.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset the outputs are idle: track_hold=0, dout_oe=0, dout_weak=0, dout=0 and conv_start=0, and every configuration register reads zero.
- R2: A chip-select fall seen while the serial clock is high opens a frame. In the same cycle track_hold goes to 1 (hold), dout_oe goes to 1 and conv_start pulses for exactly one cycle. The result word {res_chan, res_sign, res_data} is captured at that moment.
- R3: A chip-select fall seen while the serial clock is low is rejected. Until chip select rises there is no strobe, no hold, no output enable and no register write, whatever the serial clock does.
- R4: While a frame is open, dout shows bit 15 of the captured word until the first serial-clock fall. After the k-th fall it shows bit 15-k, so the order is channel MSB first, then sign, then result MSB first.
- R5: On the 16th serial-clock fall, dout_oe drops. Further serial-clock edges are ignored until chip select rises.
- R6: Input bits are taken on serial-clock falls, MSB first. Bit 1 is the write flag and bits 2-3 are the select code. Select 00 addresses the 12-bit control register, whose value is bits 4-15 (first-received bit as MSB), and that value is written on the 15th fall.
- R7: Select 01 addresses range register 1, 10 addresses range register 2 and 11 addresses the sequence register. Each is 8 bits, taken from bits 4-11 and written on the 11th fall.
- R8: A frame whose write flag is 0 leaves every configuration register unchanged.
- R9: If chip select rises before the 16th fall, dout_oe drops and track_hold returns to 0. The addressed register is written only if its commit fall has already occurred.
- R10: track_hold returns to 0 on the 14th serial-clock rise of an open frame.
- R11: Outside an open frame, if control bit 2 is 1, dout_weak=1 and dout follows res_chan MSB with dout_oe=0. If control bit 2 is 0, dout_weak=0 and dout=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, idles high |
| din | input | 1 | Serial command data, asynchronous |
| res_chan | input | 3 | Channel number of the result to report |
| res_sign | input | 1 | Sign bit of the result |
| res_data | input | 12 | Conversion result magnitude |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Strong drive enable for dout |
| dout_weak | output | 1 | Weak keeper drive active on dout |
| track_hold | output | 1 | 1 = hold, 0 = track |
| conv_start | output | 1 | One-cycle strobe when a frame opens |
| ctrl_reg | output | 12 | Control register |
| range1_reg | output | 8 | Range register 1 |
| range2_reg | output | 8 | Range register 2 |
| seq_reg | output | 8 | Sequence register |

## Verification
Two functions can act on the same serial-clock fall. The register commit on the 11th or 15th fall happens on the same fall that moves dout to its next result bit. A chip-select rise placed right after a commit fall also closes a frame whose write has just landed. Frames are driven with 16 clocks, with extra clocks, and with aborts after 12 clocks against both the 11-fall and the 15-fall commit points. A behavioural model predicts dout, enables, hold and every register. It is compared on every system clock once the synchronizer delay after the latest pin change has passed, so a commit landing with the wrong shift step, or a write leaking through an abort, shows as a mismatch.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

  typedef enum logic [1:0] {
    FR_IDLE   = 2'd0,
    FR_ACTIVE = 2'd1,
    FR_DONE   = 2'd2,
    FR_REJECT = 2'd3
  } fr_state_e;

  localparam logic [1:0] SEL_CTRL = 2'b00;
  localparam logic [1:0] SEL_RNG1 = 2'b01;
  localparam logic [1:0] SEL_RNG2 = 2'b10;
  localparam logic [1:0] SEL_SEQ  = 2'b11;

endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
      else        chain_q <= {chain_q[STAGES-2:0], d[i]};
    end
    assign q[i] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/adc_sif_frame.sv
module adc_sif_frame
  import adc_sif_pkg::*;
#(
  parameter int CTRL_W    = 12,
  parameter int AUX_W     = 8,
  parameter int FRAME_LEN = 16,
  parameter int HOLD_RISE = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              sclk_lvl,
  input  logic              din_lvl,
  output logic              active,
  output logic              start_pulse,
  output logic              hold,
  output logic              load,
  output logic              shift,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [AUX_W-1:0]  rng1_q,
  output logic [AUX_W-1:0]  rng2_q,
  output logic [AUX_W-1:0]  seq_q
);

  localparam int CTRL_COMMIT = 3 + CTRL_W;
  localparam int AUX_COMMIT  = 3 + AUX_W;
  localparam int SR_W        = CTRL_COMMIT;
  localparam int CNT_W       = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CTRL_AT = CNT_W'(CTRL_COMMIT);
  localparam logic [CNT_W-1:0] AUX_AT  = CNT_W'(AUX_COMMIT);
  localparam logic [CNT_W-1:0] END_AT  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] HOLD_AT = CNT_W'(HOLD_RISE);

  fr_state_e        state_q, state_d;
  logic [CNT_W-1:0] fall_q, fall_d, rise_q, rise_d, fall_inc;
  logic [SR_W-1:0]  sr_q, sr_d, sr_in;
  logic             hold_q, hold_d, start_q, start_d;
  logic             cs_prev_q, sclk_prev_q;
  logic             cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic             ctrl_we, aux_we;
  logic [1:0]       aux_sel;
  logic [2:0][AUX_W-1:0] aux_q;

  assign cs_fall   = cs_prev_q & ~cs_lvl;
  assign cs_rise   = ~cs_prev_q & cs_lvl;
  assign sclk_fall = sclk_prev_q & ~sclk_lvl;
  assign sclk_rise = ~sclk_prev_q & sclk_lvl;
  assign sr_in     = {sr_q[SR_W-2:0], din_lvl};
  assign fall_inc  = fall_q + 1'b1;
  assign aux_sel   = sr_in[AUX_COMMIT-2 -: 2];

  always_comb begin
    state_d = state_q;
    fall_d  = fall_q;
    rise_d  = rise_q;
    sr_d    = sr_q;
    hold_d  = hold_q;
    start_d = 1'b0;
    load    = 1'b0;
    shift   = 1'b0;
    ctrl_we = 1'b0;
    aux_we  = 1'b0;
    if (cs_fall) begin
      if (sclk_lvl) begin
        state_d = FR_ACTIVE;
        fall_d  = '0;
        rise_d  = '0;
        hold_d  = 1'b1;
        start_d = 1'b1;
        load    = 1'b1;
      end else begin
        state_d = FR_REJECT;
      end
    end else if (cs_rise) begin
      state_d = FR_IDLE;
      hold_d  = 1'b0;
    end else if (state_q == FR_ACTIVE) begin
      if (sclk_fall) begin
        fall_d = fall_inc;
        sr_d   = sr_in;
        shift  = 1'b1;
        if (fall_inc == AUX_AT && sr_in[AUX_COMMIT-1] && aux_sel != SEL_CTRL)
          aux_we = 1'b1;
        if (fall_inc == CTRL_AT && sr_in[CTRL_COMMIT-1] &&
            sr_in[CTRL_COMMIT-2 -: 2] == SEL_CTRL)
          ctrl_we = 1'b1;
        if (fall_inc == END_AT) state_d = FR_DONE;
      end
      if (sclk_rise) begin
        rise_d = rise_q + 1'b1;
        if (rise_d == HOLD_AT) hold_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= FR_IDLE;
      fall_q      <= '0;
      rise_q      <= '0;
      sr_q        <= '0;
      hold_q      <= 1'b0;
      start_q     <= 1'b0;
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b1;
    end else begin
      state_q     <= state_d;
      fall_q      <= fall_d;
      rise_q      <= rise_d;
      sr_q        <= sr_d;
      hold_q      <= hold_d;
      start_q     <= start_d;
      cs_prev_q   <= cs_lvl;
      sclk_prev_q <= sclk_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= sr_in[CTRL_W-1:0];
  end

  for (genvar g = 0; g < 3; g++) begin : g_aux
    logic we_g;
    assign we_g = aux_we && (aux_sel == 2'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    aux_q[g] <= '0;
      else if (we_g) aux_q[g] <= sr_in[AUX_W-1:0];
    end
  end

  assign rng1_q      = aux_q[SEL_RNG1 - 2'd1];
  assign rng2_q      = aux_q[SEL_RNG2 - 2'd1];
  assign seq_q       = aux_q[SEL_SEQ - 2'd1];
  assign active      = (state_q == FR_ACTIVE);
  assign hold        = hold_q;
  assign start_pulse = start_q;

endmodule

// File: rtl/adc_sif_shift.sv
module adc_sif_shift #(
  parameter int CHAN_W = 3,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              active,
  input  logic              weak_en,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic              res_sign,
  input  logic [RES_W-1:0]  res_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              dout_weak
);

  localparam int WORD_W = CHAN_W + 1 + RES_W;

  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load)       word_d = {res_chan, res_sign, res_data};
    else if (shift) word_d = {word_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              word_q <= '0;
    else if (load || shift)  word_q <= word_d;
  end

  assign dout_oe   = active;
  assign dout_weak = ~active & weak_en;
  assign dout      = active ? word_q[WORD_W-1] : (dout_weak & res_chan[CHAN_W-1]);

endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl #(
  parameter int CHAN_W      = 3,
  parameter int RES_W       = 12,
  parameter int CTRL_W      = 12,
  parameter int AUX_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_RISE   = 14,
  parameter int WEAK_BIT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic              res_sign,
  input  logic [RES_W-1:0]  res_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              dout_weak,
  output logic              track_hold,
  output logic              conv_start,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic [AUX_W-1:0]  range1_reg,
  output logic [AUX_W-1:0]  range2_reg,
  output logic [AUX_W-1:0]  seq_reg
);

  localparam int FRAME_LEN = CHAN_W + 1 + RES_W;

  logic       rst_meta_q, rst_sync_n;
  logic [2:0] pins_s;
  logic       active, load, shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  adc_sif_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({cs_n, sclk, din}),
    .q     (pins_s)
  );

  adc_sif_frame #(
    .CTRL_W    (CTRL_W),
    .AUX_W     (AUX_W),
    .FRAME_LEN (FRAME_LEN),
    .HOLD_RISE (HOLD_RISE)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cs_lvl      (pins_s[2]),
    .sclk_lvl    (pins_s[1]),
    .din_lvl     (pins_s[0]),
    .active      (active),
    .start_pulse (conv_start),
    .hold        (track_hold),
    .load        (load),
    .shift       (shift),
    .ctrl_q      (ctrl_reg),
    .rng1_q      (range1_reg),
    .rng2_q      (range2_reg),
    .seq_q       (seq_reg)
  );

  adc_sif_shift #(
    .CHAN_W (CHAN_W),
    .RES_W  (RES_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .shift     (shift),
    .active    (active),
    .weak_en   (ctrl_reg[WEAK_BIT]),
    .res_chan  (res_chan),
    .res_sign  (res_sign),
    .res_data  (res_data),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .dout_weak (dout_weak)
  );

endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk #(
  parameter int CTRL_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dout_oe,
  input logic              dout_weak,
  input logic              track_hold,
  input logic              conv_start,
  input logic [CTRL_W-1:0] ctrl_reg
);

  p_drive_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dout_oe && dout_weak));

  p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (track_hold && dout_oe));

  p_oe_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> conv_start);

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_hold_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track_hold) |-> conv_start);

  p_ctrl_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_reg) |-> $past(dout_oe));

  p_close_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe) |-> !track_hold);

endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dout_oe    (dout_oe),
  .dout_weak  (dout_weak),
  .track_hold (track_hold),
  .conv_start (conv_start),
  .ctrl_reg   (ctrl_reg)
);

// File: tb/adc_serial_ctrl_tb.sv
module adc_serial_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int SETTLE     = 3;

  logic        clk, rst_n, cs_n, sclk, din;
  logic [2:0]  res_chan;
  logic        res_sign;
  logic [11:0] res_data;
  logic        dout, dout_oe, dout_weak, track_hold, conv_start;
  logic [11:0] ctrl_reg;
  logic [7:0]  range1_reg, range2_reg, seq_reg;

  adc_serial_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .res_chan(res_chan), .res_sign(res_sign), .res_data(res_data),
    .dout(dout), .dout_oe(dout_oe), .dout_weak(dout_weak),
    .track_hold(track_hold), .conv_start(conv_start),
    .ctrl_reg(ctrl_reg), .range1_reg(range1_reg),
    .range2_reg(range2_reg), .seq_reg(seq_reg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model state, written only by the stimulus process
  int          chg_id;
  bit          m_active, m_hold;
  int          m_falls, m_rises, m_frames;
  logic [15:0] m_word;
  bit          m_bits[$];
  logic [11:0] m_ctrl;
  logic [7:0]  m_r1, m_r2, m_seq;
  bit          done;

  // compare-process state
  int cmp_checks, cmp_fails, pulses, seen_id, quiet;
  // direct-check state
  int dir_checks, dir_fails;
  bit wd_fail;

  task automatic dchk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    dir_checks++;
    if (act !== exp) begin
      dir_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(posedge clk);
  endtask

  task automatic set_res(input logic [2:0] c, input logic s, input logic [11:0] d);
    @(posedge clk); #1;
    res_chan = c; res_sign = s; res_data = d;
    chg_id++;
    wait_half();
  endtask

  task automatic set_din(input bit v);
    @(posedge clk); #1;
    din = v;
    chg_id++;
    wait_half();
  endtask

  task automatic set_cs(input bit v);
    @(posedge clk); #1;
    cs_n = v;
    if (!v) begin
      if (sclk) begin
        m_active = 1'b1; m_hold = 1'b1;
        m_falls = 0; m_rises = 0;
        m_bits.delete();
        m_word = {res_chan, res_sign, res_data};
        m_frames++;
      end
    end else begin
      m_active = 1'b0; m_hold = 1'b0;
    end
    chg_id++;
    wait_half();
  endtask

  task automatic set_sclk(input bit v);
    @(posedge clk); #1;
    sclk = v;
    if (m_active) begin
      if (!v) begin
        m_falls++;
        m_bits.push_back(din);
        if (m_falls == 11 && m_bits[0] && {m_bits[1], m_bits[2]} != 2'b00) begin
          logic [7:0] d8;
          for (int i = 0; i < 8; i++) d8[7-i] = m_bits[3+i];
          case ({m_bits[1], m_bits[2]})
            2'b01:   m_r1  = d8;
            2'b10:   m_r2  = d8;
            default: m_seq = d8;
          endcase
        end
        if (m_falls == 15 && m_bits[0] && {m_bits[1], m_bits[2]} == 2'b00) begin
          for (int i = 0; i < 12; i++) m_ctrl[11-i] = m_bits[3+i];
        end
        if (m_falls == 16) m_active = 1'b0;
      end else begin
        m_rises++;
        if (m_rises == 14) m_hold = 1'b0;
      end
    end
    chg_id++;
    wait_half();
  endtask

  // frame of n serial clocks; chip select rises afterwards
  task automatic frame(input logic [15:0] w, input int n);
    set_cs(1'b0);
    for (int i = 0; i < n; i++) begin
      set_din(i < 16 ? w[15-i] : 1'b0);
      set_sclk(1'b0);
      set_sclk(1'b1);
    end
    set_cs(1'b1);
  endtask

  function automatic logic [15:0] cmd_ctrl(input bit w, input logic [11:0] d);
    return {w, 2'b00, d, 1'b0};
  endfunction

  function automatic logic [15:0] cmd_aux(input bit w, input logic [1:0] sel, input logic [7:0] d);
    return {w, sel, d, 5'b0};
  endfunction

  // cycle-by-cycle comparison once the pins have settled through the synchronizer
  always @(negedge clk) begin
    if (!rst_n) begin
      quiet <= 0;
    end else begin
      if (conv_start === 1'b1) pulses = pulses + 1;
      if (chg_id != seen_id) begin
        seen_id = chg_id;
        quiet   = 0;
      end else if (quiet < 1000) begin
        quiet = quiet + 1;
      end
      if (quiet >= SETTLE) begin
        logic e_weak, e_dout;
        e_weak = !m_active && m_ctrl[2];
        e_dout = m_active ? m_word[15 - m_falls] : (e_weak & res_chan[2]);
        cmp_checks = cmp_checks + 8;
        if (dout_oe !== m_active) begin
          cmp_fails++; $display("FAIL R5 dout_oe actual=%0b expected=%0b", dout_oe, m_active);
        end
        if (dout !== e_dout) begin
          cmp_fails++; $display("FAIL R4 dout actual=%0b expected=%0b", dout, e_dout);
        end
        if (dout_weak !== e_weak) begin
          cmp_fails++; $display("FAIL R11 dout_weak actual=%0b expected=%0b", dout_weak, e_weak);
        end
        if (track_hold !== m_hold) begin
          cmp_fails++; $display("FAIL R10 track_hold actual=%0b expected=%0b", track_hold, m_hold);
        end
        if (ctrl_reg !== m_ctrl) begin
          cmp_fails++; $display("FAIL R6 ctrl_reg actual=%0h expected=%0h", ctrl_reg, m_ctrl);
        end
        if (range1_reg !== m_r1 || range2_reg !== m_r2) begin
          cmp_fails++; $display("FAIL R7 range actual=%0h/%0h expected=%0h/%0h",
                                range1_reg, range2_reg, m_r1, m_r2);
        end
        if (seq_reg !== m_seq) begin
          cmp_fails++; $display("FAIL R7 seq_reg actual=%0h expected=%0h", seq_reg, m_seq);
        end
        if (pulses != m_frames) begin
          cmp_fails++; $display("FAIL R2 conv_start count actual=%0d expected=%0d", pulses, m_frames);
        end
      end
    end
  end

  // stimulus
  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b0;
    res_chan = 3'd0; res_sign = 1'b0; res_data = 12'd0;
    chg_id = 0; m_active = 0; m_hold = 0; m_falls = 0; m_rises = 0; m_frames = 0;
    m_word = '0; m_ctrl = '0; m_r1 = '0; m_r2 = '0; m_seq = '0; done = 0;
    dir_checks = 0; dir_fails = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    chg_id++;
    repeat (8) @(posedge clk);

    // R1: idle after reset
    dchk("R1 dout_oe", dout_oe, 0);
    dchk("R1 track_hold", track_hold, 0);
    dchk("R1 dout/weak/start", {dout, dout_weak, conv_start}, 0);
    dchk("R1 regs", {ctrl_reg, range1_reg, range2_reg, seq_reg}, 0);

    // R6: control write sets weak bit (bit 2)
    set_res(3'd5, 1'b1, 12'hABC);
    frame(cmd_ctrl(1'b1, 12'h5A4), 16);
    dchk("R6 ctrl value", ctrl_reg, 12'h5A4);
    dchk("R11 weak level chan msb=1", {dout_weak, dout_oe, dout}, 3'b101);
    set_res(3'd3, 1'b0, 12'h123);
    dchk("R11 weak level chan msb=0", {dout_weak, dout}, 2'b10);

    // R7: the three 8-bit registers, one frame with extra clocks (R5)
    frame(cmd_aux(1'b1, 2'b01, 8'h3C), 16);
    set_res(3'd6, 1'b1, 12'hF0F);
    frame(cmd_aux(1'b1, 2'b10, 8'hA5), 18);
    set_res(3'd1, 1'b0, 12'h800);
    frame(cmd_aux(1'b1, 2'b11, 8'h77), 16);
    dchk("R7 range1", range1_reg, 8'h3C);
    dchk("R7 range2", range2_reg, 8'hA5);
    dchk("R7 seq", seq_reg, 8'h77);

    // R8: write flag clear
    frame(cmd_ctrl(1'b0, 12'hFFF), 16);
    frame(cmd_aux(1'b0, 2'b01, 8'hEE), 16);
    dchk("R8 ctrl unchanged", ctrl_reg, 12'h5A4);
    dchk("R8 range1 unchanged", range1_reg, 8'h3C);

    // R9: abort after 12 clocks, before the control commit and after the 8-bit commit
    set_res(3'd7, 1'b1, 12'h555);
    frame(cmd_ctrl(1'b1, 12'h0F0), 12);
    dchk("R9 ctrl write suppressed", ctrl_reg, 12'h5A4);
    dchk("R9 track after abort", {track_hold, dout_oe}, 2'b00);
    frame(cmd_aux(1'b1, 2'b01, 8'h99), 12);
    dchk("R9 range1 committed before abort", range1_reg, 8'h99);
    frame(cmd_ctrl(1'b1, 12'h0F0), 15);
    dchk("R9 ctrl committed on 15th", ctrl_reg, 12'h0F0);

    // R3: frame opened with serial clock low is rejected
    set_sclk(1'b0);
    set_cs(1'b0);
    for (int i = 0; i < 12; i++) begin
      set_din(1'b1);
      set_sclk(1'b1);
      set_sclk(1'b0);
    end
    dchk("R3 no enable", {dout_oe, track_hold}, 2'b00);
    dchk("R3 no strobe", pulses, m_frames);
    dchk("R3 no write", ctrl_reg, 12'h0F0);
    set_cs(1'b1);
    set_sclk(1'b1);

    // R11: clear weak bit, then line released
    set_res(3'd4, 1'b0, 12'h00F);
    frame(cmd_ctrl(1'b1, 12'h000), 16);
    dchk("R11 released", {dout_weak, dout_oe, dout}, 3'b000);
    dchk("R10 track after full frame", track_hold, 0);

    repeat (10) @(posedge clk);
    done = 1'b1;
  end

  // supervisor: normal end or watchdog, one summary either way
  initial begin
    wd_fail = 1'b0;
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        wd_fail = 1'b1;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             cmp_checks + dir_checks + (wd_fail ? 1 : 0),
             cmp_fails + dir_fails + (wd_fail ? 1 : 0));
    $finish;
  end

  initial begin
    cmp_checks = 0; cmp_fails = 0; pulses = 0; seen_id = 0; quiet = 0;
  end

endmodule